// File: doc/BRIEF.md
# Carry-Pipelined Constant-Addend Accumulator

This block is a wide phase accumulator for a fixed addend, as used to drive the modulus control of a fractional divider. The word is cut into narrow slices. Each slice is summed by its own small carry-lookahead adder. The carry leaving a slice is registered and reaches the slice above on the next clock, so the longest combinational path is one slice wide and no longer grows with the accumulator width.

The addend stays constant between resets. For that reason the block has no skew registers on the addend and no de-skew registers on the result. Each slice of the result therefore trails the slice below it by one cycle. The top slice's registered carry is the overflow bit. Its long-run density is the addend divided by 2^W, which is what the divider needs.

Top module: `cpacc_top`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low, and in the first cycle after it rises, `acc_value` is 0, `overflow` is 0 and no carry is pending.
- R2: The width is W = SEG_W·NUM_SEG. The lowest slice (bits SEG_W-1..0) receives no carry. At every clock it advances by the lowest addend slice, modulo 2^SEG_W.
- R3: A carry out of slice i is held in a register and is added into slice i+1 on the next clock only. The weighted total of `acc_value`, the pending carries and `overflow`·2^W therefore grows by exactly the addend at each clock.
- R4: `overflow` is the registered carry out of the top slice. It is high for one cycle per carry.
- R5: Hold the addend K from reset release and let K_j be slice j of K. Define A(τ) = Σ_j K_j·2^(SEG_W·j)·max(0, τ+j). At cycle t after release, slice i of `acc_value` equals slice i of A(t−i). `overflow` is 1 exactly when ⌊A(t−NUM_SEG+1)/2^W⌋ exceeds ⌊A(t−NUM_SEG)/2^W⌋.
- R6: After the NUM_SEG-cycle fill, any 2^W consecutive cycles hold exactly K overflow pulses.
- R7: With a zero addend and no pending carry, `acc_value` holds its value and no overflow occurs.
- R8: A new addend applied during reset takes effect from release. Nothing from the previous addend remains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addend | input | SEG_W·NUM_SEG | Constant addend, changed only under reset |
| acc_value | output | SEG_W·NUM_SEG | Slice-skewed accumulator contents |
| overflow | output | 1 | Registered carry out of the top slice |

## Verification
The bench targets the fill interval, when upper slices run ahead of the carries that are still climbing towards them. A design that treated the result as a plainly delayed ideal sum would produce wrong overflow pulses there. An all-ones addend makes every slice propagate. A slip of one cycle in the carry hop, or a carry that is lost or applied twice, shows up at once in the slice values and in the overflow timing. A reduced-width instance is run for a full period to confirm the overflow density. A zero addend, and addend changes made under reset, catch stale carries and carries that are never cleared.

// File: rtl/cpacc_pkg.sv
package cpacc_pkg;
  typedef struct packed {
    logic prop;
    logic gen;
  } pg_t;

  function automatic pg_t bit_pg(input logic a, input logic b);
    pg_t r;
    r.prop = a ^ b;
    r.gen  = a & b;
    return r;
  endfunction
endpackage

// File: rtl/cpacc_cla.sv
module cpacc_cla #(
  parameter int SEG_W = 4
) (
  input  logic [SEG_W-1:0] a_in,
  input  logic [SEG_W-1:0] b_in,
  input  logic             c_in,
  output logic [SEG_W-1:0] sum_out,
  output logic             c_out
);
  import cpacc_pkg::*;

  logic [SEG_W-1:0] p_vec;
  logic [SEG_W-1:0] g_vec;
  logic [SEG_W:0]   c_vec;

  // carry into bit j as a flat sum of products (lookahead form)
  function automatic logic la_carry(input logic [SEG_W-1:0] p, input logic [SEG_W-1:0] g,
                                    input logic cin, input int j);
    logic res;
    logic chain;
    res = 1'b0;
    for (int m = 0; m < SEG_W; m++) begin
      if (m < j) begin
        chain = g[m];
        for (int q = 0; q < SEG_W; q++) begin
          if (q > m && q < j) chain = chain & p[q];
        end
        res = res | chain;
      end
    end
    chain = cin;
    for (int q = 0; q < SEG_W; q++) begin
      if (q < j) chain = chain & p[q];
    end
    return res | chain;
  endfunction

  for (genvar b = 0; b < SEG_W; b++) begin : g_pg
    pg_t pg;
    assign pg       = bit_pg(a_in[b], b_in[b]);
    assign p_vec[b] = pg.prop;
    assign g_vec[b] = pg.gen;
  end

  for (genvar j = 0; j <= SEG_W; j++) begin : g_carry
    assign c_vec[j] = la_carry(p_vec, g_vec, c_in, j);
  end

  assign sum_out = p_vec ^ c_vec[SEG_W-1:0];
  assign c_out   = c_vec[SEG_W];
endmodule

// File: rtl/cpacc_stage.sv
module cpacc_stage #(
  parameter int SEG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEG_W-1:0] k_slice,
  input  logic             carry_in,
  output logic [SEG_W-1:0] sum_q,
  output logic             carry_q
);
  logic [SEG_W-1:0] sum_d;
  logic             carry_d;

  cpacc_cla #(.SEG_W(SEG_W)) u_cla (
    .a_in   (sum_q),
    .b_in   (k_slice),
    .c_in   (carry_in),
    .sum_out(sum_d),
    .c_out  (carry_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      sum_q   <= sum_d;
      carry_q <= carry_d;
    end
  end
endmodule

// File: rtl/cpacc_top.sv
module cpacc_top #(
  parameter int SEG_W   = 4,
  parameter int NUM_SEG = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SEG_W*NUM_SEG-1:0] addend,
  output logic [SEG_W*NUM_SEG-1:0] acc_value,
  output logic                     overflow
);
  localparam int W = SEG_W * NUM_SEG;

  // registered carry out of each slice, brought out for the checker
  logic [NUM_SEG-1:0] carry_vec;
  logic [NUM_SEG-1:0] carry_feed;

  assign carry_feed[0] = 1'b0;

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    if (i > 0) begin : g_link
      assign carry_feed[i] = carry_vec[i-1];
    end
    cpacc_stage #(.SEG_W(SEG_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .k_slice (addend[i*SEG_W +: SEG_W]),
      .carry_in(carry_feed[i]),
      .sum_q   (acc_value[i*SEG_W +: SEG_W]),
      .carry_q (carry_vec[i])
    );
  end

  assign overflow = carry_vec[NUM_SEG-1];

  logic unused_w;
  assign unused_w = (W == 0);
endmodule

// File: rtl/cpacc_chk.sv
module cpacc_chk #(
  parameter int SEG_W   = 4,
  parameter int NUM_SEG = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [SEG_W*NUM_SEG-1:0] addend,
  input logic [SEG_W*NUM_SEG-1:0] acc_value,
  input logic                     overflow,
  input logic [NUM_SEG-1:0]       carry_vec
);
  localparam int W = SEG_W * NUM_SEG;

  logic [W+1:0] held_total;
  logic [W+1:0] now_total;

  always_comb begin
    held_total = {2'b00, acc_value};
    for (int i = 0; i < NUM_SEG - 1; i++) begin
      if (carry_vec[i]) held_total = held_total + ((W+2)'(1) << (SEG_W * (i + 1)));
    end
    now_total = held_total + ({1'b0, overflow, {W{1'b0}}});
  end

  a_r1_clean_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (acc_value == '0 && !overflow && carry_vec == '0));

  a_r2_low_slice_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> acc_value[SEG_W-1:0] ==
      SEG_W'($past(acc_value[SEG_W-1:0]) + $past(addend[SEG_W-1:0])));

  a_r3_carry_conserved: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> now_total == $past(held_total) + {2'b00, $past(addend)});

  a_r7_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(addend) == '0 && $past(carry_vec) == '0) |->
      (acc_value == $past(acc_value) && carry_vec == '0 && !overflow));
endmodule

bind cpacc_top cpacc_chk #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addend   (addend),
  .acc_value(acc_value),
  .overflow (overflow),
  .carry_vec(carry_vec)
);

// File: tb/tb_cpacc_top.sv
`timescale 1ns/1ps
module tb_cpacc_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;

  logic        rst_b = 1'b0;
  logic [23:0] add_b = '0;
  logic [23:0] acc_b;
  logic        ovf_b;
  logic        rst_s = 1'b0;
  logic [11:0] add_s = '0;
  logic [11:0] acc_s;
  logic        ovf_s;

  cpacc_top dut (.clk(clk), .rst_n(rst_b), .addend(add_b), .acc_value(acc_b), .overflow(ovf_b));
  cpacc_top #(.SEG_W(4), .NUM_SEG(3)) dut_small (.clk(clk), .rst_n(rst_s), .addend(add_s),
    .acc_value(acc_s), .overflow(ovf_s));

  // ideal sum with every slice starting its additions at its own offset
  function automatic longint ideal(longint k, int ns, longint tau);
    longint a = 0;
    for (int i = 0; i < ns; i++) begin
      longint ki = (k >> (4 * i)) & 64'hF;
      longint n  = tau + i;
      if (n > 0) a += (ki << (4 * i)) * n;
    end
    return a;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare(input longint k, input int ns, input longint t,
                         input longint acc, input bit ovf);
    longint exp_acc = 0;
    longint w = 4 * ns;
    bit exp_ovf;
    for (int i = 0; i < ns; i++)
      exp_acc |= ((ideal(k, ns, t - i) >> (4 * i)) & 64'hF) << (4 * i);
    exp_ovf = ((ideal(k, ns, t - ns + 1) >> w) != (ideal(k, ns, t - ns) >> w));
    check(acc == exp_acc, "R3/R5 slice values", acc, exp_acc);
    check(ovf == exp_ovf, "R4/R5 overflow", longint'(ovf), longint'(exp_ovf));
  endtask

  task automatic run_big(input logic [23:0] k, input int cycles);
    int pulses = 0;
    @(negedge clk);
    rst_b = 1'b0;
    add_b = k;
    repeat (3) @(negedge clk);
    check(acc_b == '0 && !ovf_b, "R1/R8 reset state", longint'(acc_b), 0);
    rst_b = 1'b1;
    for (int t = 1; t <= cycles; t++) begin
      @(posedge clk);
      @(negedge clk);
      compare(longint'(k), 6, t, longint'(acc_b), ovf_b);
      check(acc_b[3:0] == 4'(t * k[3:0]), "R2 low slice", longint'(acc_b[3:0]),
            longint'(4'(t * k[3:0])));
      if (ovf_b) pulses++;
    end
    if (k == '0) check(acc_b == '0 && pulses == 0, "R7 zero addend", longint'(pulses), 0);
  endtask

  task automatic run_small(input logic [11:0] k);
    int pulses = 0;
    @(negedge clk);
    rst_s = 1'b0;
    add_s = k;
    repeat (3) @(negedge clk);
    check(acc_s == '0 && !ovf_s, "R1 reset state small", longint'(acc_s), 0);
    rst_s = 1'b1;
    for (int t = 1; t <= 4200; t++) begin
      @(posedge clk);
      @(negedge clk);
      compare(longint'(k), 3, t, longint'(acc_s), ovf_s);
      if (t >= 10 && t < 10 + 4096 && ovf_s) pulses++;
    end
    check(pulses == int'(k), "R6 overflow density", longint'(pulses), longint'(k));
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    run_big(24'h000001, 60);
    run_big(24'hFFFFFF, 200);   // every slice propagates
    run_big(24'h800000, 80);
    run_big(24'h0F0F0F, 120);
    run_big(24'h000000, 60);    // R7
    run_big(24'hA5C3E7, 150);   // R8: new addend after prior run
    run_small(12'h5A3);
    run_small(12'h001);
    run_small(12'hFFF);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule